// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder/Subtractor

This block adds or subtracts two two's-complement operands in a single combinational pass. Every bit forms a generate term (both operand bits set) and a propagate term (operand bits differ). Bits are gathered into groups of four, and each carry inside a group is written as a flat sum of products of that group's generate, propagate and carry-in terms. Each group also reports its own generate and propagate. A second lookahead level turns those group terms into the carry-in of every group at once, so no carry has to travel from one group to the next.

Subtraction adds the two's complement of the second operand. A mode input passes operand B through XOR gates, so B is inverted when the mode is high. The same input is the carry-in into bit 0 and supplies the +1. The outputs are the sum, the raw carry out of the most significant bit, and a signed overflow flag. The overflow flag is the XOR of the carry into the top bit and the carry out of it. The operand width is a parameter and must be a multiple of four.

Top module: `cla_addsub`

## Requirements
- R1: With `sub` = 0, `sum` equals (`op_a` + `op_b`) modulo 2^WIDTH.
- R2: With `sub` = 0, `cout` equals bit WIDTH of the unsigned (WIDTH+1)-bit sum `op_a` + `op_b`.
- R3: With `sub` = 1, `sum` equals (`op_a` - `op_b`) modulo 2^WIDTH.
- R4: With `sub` = 1, `cout` is 1 exactly when `op_a` >= `op_b` as unsigned numbers. A value of 1 means no borrow.
- R5: With `sub` = 0, `ovf` is 1 exactly when the signed sum of the operands lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1].
- R6: With `sub` = 1, `ovf` is 1 exactly when the signed difference `op_a` - `op_b` lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1].
- R7: A carry born in bit 0 reaches every group. All ones plus one gives `sum` = 0 and `cout` = 1. Zero minus one gives all ones with `cout` = 0. The carry that each 4-bit group forms internally equals the carry-in that the second level hands to the next group.
- R8: WIDTH is a parameter, a multiple of 4, with a default of 16. R1 to R6 hold at the default width as well as at reduced widths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand (minuend when subtracting) |
| op_b | input | WIDTH | Second operand (subtrahend when subtracting) |
| sub | input | 1 | 0 = add, 1 = subtract |
| sum | output | WIDTH | Result modulo 2^WIDTH |
| cout | output | 1 | Carry out of the most significant bit |
| ovf | output | 1 | Signed two's-complement overflow |

## Verification
An 8-bit instance is swept over every operand pair in both modes. This reaches every pattern of generate, propagate and kill at each group boundary. A wrong term in any flat carry expression would therefore corrupt some sum bit above that boundary. Long propagate chains are covered too, such as all ones plus one and zero minus one. A second-level unit that rippled wrongly, or that dropped the external carry-in, would give wrong high bits or a wrong carry-out there. Subtraction is checked for a forgotten +1, which would leave every difference one short. It is also checked for carry-out polarity, because a borrow-style flag would invert `cout` for every pair with A >= B. Overflow is checked at the signed extremes, where a flag taken from the carry-out alone would be wrong. A default 16-bit instance then runs corner and random vectors to cover the four-group hierarchy.

// File: rtl/cla_pkg.sv
// Shared constants for the grouped carry-lookahead adder.
// Assumes: group size is fixed at four bits throughout the hierarchy.
package cla_pkg;
    localparam int GRP_BITS = 4;
endpackage

// File: rtl/cla_pg_stage.sv
// Per-bit generate/propagate stage with operand-B conditional inversion.
// What it does: b_eff = op_b XOR sub; g = a AND b_eff; p = a XOR b_eff.
// Assumes: sub is the add/subtract selector; purely combinational.
module cla_pg_stage #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             sub,
    output logic [WIDTH-1:0] gen,
    output logic [WIDTH-1:0] prop
);
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            logic b_eff;
            // Invert B for subtraction, then form this bit's G and P.
            always_comb begin
                b_eff   = op_b[i] ^ sub;
                gen[i]  = op_a[i] & b_eff;
                prop[i] = op_a[i] ^ b_eff;
            end
        end
    endgenerate
endmodule

// File: rtl/cla_group4.sv
// Four-bit lookahead group.
// What it does: expands every internal carry as a flat sum of products of
// this group's g, p and carry-in; also reports group generate/propagate.
// Assumes: carry-in arrives from the second-level lookahead unit.
module cla_group4 (
    input  logic [3:0] gen,
    input  logic [3:0] prop,
    input  logic       cin,
    output logic [3:0] bit_cin,
    output logic       grp_cout,
    output logic       grp_gen,
    output logic       grp_prop
);
    logic c0, c1, c2, c3;

    // Flat carries out of bits 0..3, each a two-level AND-OR of g, p, cin.
    always_comb begin
        c0 = gen[0] | (prop[0] & cin);
        c1 = gen[1] | (prop[1] & gen[0]) | (prop[1] & prop[0] & cin);
        c2 = gen[2] | (prop[2] & gen[1]) | (prop[2] & prop[1] & gen[0])
           | (prop[2] & prop[1] & prop[0] & cin);
        c3 = gen[3] | (prop[3] & gen[2]) | (prop[3] & prop[2] & gen[1])
           | (prop[3] & prop[2] & prop[1] & gen[0])
           | (prop[3] & prop[2] & prop[1] & prop[0] & cin);
    end

    // Carry into each bit of the group and the group's own carry-out.
    always_comb begin
        bit_cin  = {c2, c1, c0, cin};
        grp_cout = c3;
    end

    // Group generate/propagate, independent of the carry-in.
    always_comb begin
        grp_gen  = gen[3] | (prop[3] & gen[2]) | (prop[3] & prop[2] & gen[1])
                 | (prop[3] & prop[2] & prop[1] & gen[0]);
        grp_prop = &prop;
    end
endmodule

// File: rtl/cla_lookahead.sv
// Second-level lookahead unit.
// What it does: from group generate/propagate terms and the external
// carry-in, forms the carry into every group in parallel (flat form:
// carry out of group j = OR over k<=j of GG[k] & GP[k+1..j], OR cin & GP[0..j]).
// Assumes: NGRP is modest (fan-in grows with the group count).
module cla_lookahead #(
    parameter int NGRP = 4
) (
    input  logic [NGRP-1:0] grp_gen,
    input  logic [NGRP-1:0] grp_prop,
    input  logic            cin,
    output logic [NGRP:0]   grp_carry
);
    // Flat sum of products for each group boundary; no carry feeds another.
    always_comb begin : p_flat
        logic acc;
        logic term;
        grp_carry[0] = cin;
        for (int j = 0; j < NGRP; j++) begin
            acc = cin;
            for (int m = 0; m <= j; m++) acc = acc & grp_prop[m];
            for (int k = 0; k <= j; k++) begin
                term = grp_gen[k];
                for (int m = k + 1; m <= j; m++) term = term & grp_prop[m];
                acc = acc | term;
            end
            grp_carry[j+1] = acc;
        end
    end
endmodule

// File: rtl/cla_addsub.sv
// Grouped carry-lookahead adder/subtractor (top).
// What it does: sum = A + (B xor sub) + sub with two-level lookahead carries,
// raw carry-out and signed overflow (carry into MSB xor carry out of MSB).
// Assumes: WIDTH is a positive multiple of four; fully combinational.
module cla_addsub #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    import cla_pkg::*;

    localparam int NGRP = WIDTH / GRP_BITS;

    logic [WIDTH-1:0] gen;
    logic [WIDTH-1:0] prop;
    logic [WIDTH-1:0] bit_cin;
    logic [NGRP-1:0]  grp_gen;
    logic [NGRP-1:0]  grp_prop;
    logic [NGRP-1:0]  grp_cout;
    logic [NGRP:0]    grp_carry;

    cla_pg_stage #(.WIDTH(WIDTH)) u_pg (
        .op_a (op_a),
        .op_b (op_b),
        .sub  (sub),
        .gen  (gen),
        .prop (prop)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NGRP; gi++) begin : g_grp
            cla_group4 u_grp (
                .gen      (gen[gi*GRP_BITS +: GRP_BITS]),
                .prop     (prop[gi*GRP_BITS +: GRP_BITS]),
                .cin      (grp_carry[gi]),
                .bit_cin  (bit_cin[gi*GRP_BITS +: GRP_BITS]),
                .grp_cout (grp_cout[gi]),
                .grp_gen  (grp_gen[gi]),
                .grp_prop (grp_prop[gi])
            );
        end
    endgenerate

    cla_lookahead #(.NGRP(NGRP)) u_la (
        .grp_gen   (grp_gen),
        .grp_prop  (grp_prop),
        .cin       (sub),
        .grp_carry (grp_carry)
    );

    // Sum bits and flags from the lookahead carries.
    always_comb begin
        sum  = prop ^ bit_cin;
        cout = grp_carry[NGRP];
        ovf  = bit_cin[WIDTH-1] ^ grp_carry[NGRP];
    end
endmodule

// File: rtl/cla_addsub_chk.sv
// Checker for cla_addsub: arithmetic properties at the ports plus agreement
// between each group's internal carry-out and the second-level carry.
// Assumes: evaluated combinationally after the design settles.
module cla_addsub_chk #(
    parameter int WIDTH = 16,
    parameter int NGRP  = WIDTH / 4
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             sub,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic             ovf,
    input logic [NGRP-1:0]  grp_cout,
    input logic [NGRP:0]    grp_carry
);
    logic [WIDTH:0] ref_add;
    logic [WIDTH:0] ref_sub;
    logic           sgn_a, sgn_b, sgn_s;

    // Reference results and sign bits used by the immediate assertions.
    always_comb begin
        ref_add = {1'b0, op_a} + {1'b0, op_b};
        ref_sub = {1'b0, op_a} - {1'b0, op_b};
        sgn_a   = op_a[WIDTH-1];
        sgn_b   = op_b[WIDTH-1];
        sgn_s   = sum[WIDTH-1];
    end

    // Port-level arithmetic properties.
    always_comb begin
        if (!sub) begin
            p_add_sum_r1:  assert (sum == ref_add[WIDTH-1:0]);
            p_add_cout_r2: assert (cout == ref_add[WIDTH]);
            p_add_ovf_r5:  assert (ovf == ((sgn_a == sgn_b) && (sgn_s != sgn_a)));
        end else begin
            p_sub_sum_r3:  assert (sum == ref_sub[WIDTH-1:0]);
            p_sub_cout_r4: assert (cout == (op_a >= op_b));
            p_sub_ovf_r6:  assert (ovf == ((sgn_a != sgn_b) && (sgn_s != sgn_a)));
        end
    end

    // Group-local carry-out must match the second-level carry (R7).
    always_comb begin
        for (int k = 0; k < NGRP; k++) begin
            p_grp_carry_r7: assert (grp_cout[k] == grp_carry[k+1]);
        end
    end
endmodule

bind cla_addsub cla_addsub_chk #(.WIDTH(WIDTH), .NGRP(WIDTH / 4)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .sub       (sub),
    .sum       (sum),
    .cout      (cout),
    .ovf       (ovf),
    .grp_cout  (grp_cout),
    .grp_carry (grp_carry)
);

// File: tb/cla_addsub_bench.sv
module cla_addsub_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 8;
    localparam int WW = 16;
    localparam int WATCHDOG_CYCLES = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   checks = 0;
    int   failures = 0;
    int   cycles = 0;
    bit   finished = 1'b0;

    logic [NW-1:0] n_a, n_b, n_sum;
    logic          n_sub, n_cout, n_ovf;
    logic [WW-1:0] w_a, w_b, w_sum;
    logic          w_sub, w_cout, w_ovf;

    always #(CLK_PERIOD/2) clk = ~clk;

    cla_addsub #(.WIDTH(NW)) u_cla_addsub (
        .op_a(n_a), .op_b(n_b), .sub(n_sub),
        .sum(n_sum), .cout(n_cout), .ovf(n_ovf)
    );

    cla_addsub u_cla_addsub_wide (
        .op_a(w_a), .op_b(w_b), .sub(w_sub),
        .sum(w_sum), .cout(w_cout), .ovf(w_ovf)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG_CYCLES && !finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG_CYCLES);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Arithmetic model: results from integer arithmetic on the operands.
    task automatic model(input int w, input longint a, input longint b, input bit s,
                         output longint e_sum, output bit e_cout, output bit e_ovf);
        longint modv = 64'sd1 << w;
        longint half = 64'sd1 << (w - 1);
        longint sa = (a >= half) ? a - modv : a;
        longint sb = (b >= half) ? b - modv : b;
        longint sres;
        if (!s) begin
            e_sum  = (a + b) % modv;
            e_cout = (a + b) >= modv;
            sres   = sa + sb;
        end else begin
            e_sum  = (a - b + modv) % modv;
            e_cout = (a >= b);
            sres   = sa - sb;
        end
        e_ovf = (sres < -half) || (sres >= half);
    endtask

    task automatic run_narrow(input int a, input int b, input bit s);
        longint es; bit ec, eo;
        n_a = a[NW-1:0]; n_b = b[NW-1:0]; n_sub = s;
        #1;
        model(NW, a, b, s, es, ec, eo);
        chk(longint'(n_sum) == es, s ? "R3" : "R1", "narrow sum", n_sum, es);
        chk(n_cout == ec, s ? "R4" : "R2", "narrow cout", n_cout, ec);
        chk(n_ovf == eo, s ? "R6" : "R5", "narrow ovf", n_ovf, eo);
    endtask

    task automatic run_wide(input longint a, input longint b, input bit s);
        longint es; bit ec, eo;
        w_a = a[WW-1:0]; w_b = b[WW-1:0]; w_sub = s;
        #1;
        model(WW, a, b, s, es, ec, eo);
        // R8: default width behaves per R1 to R6
        chk(longint'(w_sum) == es, "R8", "wide sum", w_sum, es);
        chk(w_cout == ec, "R8", "wide cout", w_cout, ec);
        chk(w_ovf == eo, "R8", "wide ovf", w_ovf, eo);
    endtask

    initial begin
        n_a = '0; n_b = '0; n_sub = 1'b0;
        w_a = '0; w_b = '0; w_sub = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        // Reset-time state with zero operands: all outputs zero (R1).
        chk(n_sum == '0 && !n_cout && !n_ovf, "R1", "zero inputs",
            {n_cout, n_ovf, n_sum}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: full-length carry propagation, both widths.
        run_narrow(255, 1, 1'b0);
        chk(n_sum == '0 && n_cout, "R7", "ones+1", {n_cout, n_sum}, 9'h100);
        run_narrow(0, 1, 1'b1);
        chk(n_sum == 8'hFF && !n_cout, "R7", "0-1", {n_cout, n_sum}, 9'h0FF);
        run_wide(64'hFFFF, 1, 1'b0);
        chk(w_sum == '0 && w_cout, "R7", "wide ones+1", {w_cout, w_sum}, 17'h10000);
        run_wide(0, 1, 1'b1);
        chk(w_sum == 16'hFFFF && !w_cout, "R7", "wide 0-1", {w_cout, w_sum}, 17'h0FFFF);

        // Exhaustive 8-bit sweep, add then subtract (R1 to R6).
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b++)
                    run_narrow(a, b, s[0]);

        // 16-bit signed extremes and random vectors (R5, R6, R8).
        run_wide(64'h7FFF, 1, 1'b0);
        run_wide(64'h8000, 64'hFFFF, 1'b0);
        run_wide(64'h8000, 1, 1'b1);
        run_wide(64'h7FFF, 64'hFFFF, 1'b1);
        run_wide(64'h8000, 64'h8000, 1'b1);
        run_wide(64'h0F0F, 64'hF0F1, 1'b0);
        for (int i = 0; i < 4000; i++)
            run_wide(longint'($urandom_range(0, 65535)),
                     longint'($urandom_range(0, 65535)), i[0]);

        finished = 1'b1;
        summary();
    end
endmodule